// File: doc/BRIEF.md
# SPI Serial Clock Generator

This block turns the system clock into the serial clock of an SPI master. An 8-bit modulus counter counts system clocks. Each time the count reaches the programmed divider, the serial clock changes level and the counter starts again. Each half-period therefore lasts exactly the divider value in system clocks, and the serial clock runs at the system clock frequency divided by twice the divider. Divider values of 0 and 1 switch the generator off. The divider register comes out of reset holding 4, which gives one eighth of the system clock.

A transfer begins when the run request is seen high while the generator is idle. A transfer is `BITS` serial clock periods, so it makes 2×`BITS` serial clock edges. During a transfer the generator raises a shift strobe on each edge that should launch outgoing data and a sample strobe on each edge that should capture incoming data. A strobe is high during the system clock cycle whose closing edge moves the serial clock, so a shift register clocked by the system clock acts on the same edge. Polarity and phase are taken from their inputs when the transfer starts. Between transfers the serial clock follows the polarity input.

The divider register is written through a load strobe. A load is accepted only while the generator is idle.

Top module: `spi_sclk_gen`

## Requirements
- R1: For a divider D from 2 to 255, every serial clock half-period in a transfer lasts exactly D system clocks, so the serial clock runs at the system clock frequency divided by 2·D.
- R2: When runReq is high on a rising clock edge while idle, the divider is at least 2 and divLoad is low, busy is high from the next cycle. busy stays high for 2·BITS·D cycles, with BITS = 8 by default. The serial clock makes 2·BITS edges in that time, and the last edge returns it to its inactive level in the same edge that clears busy.
- R3: With a divider of 0 or 1, runReq is ignored. busy stays low, no strobe appears, and sclk stays at its inactive level.
- R4: After reset, busy is low, both strobes are low and the divider holds 4. A transfer started without any divider load therefore has half-periods of 4 system clocks.
- R5: While busy is low, sclk equals the cpol input and changes with it.
- R6: Phase 0: shiftStrobe is high combinationally in the cycle in which a start is accepted. sampleStrobe marks every leading edge, and shiftStrobe marks every trailing edge except the last. Phase 1: shiftStrobe marks every leading edge and sampleStrobe marks every trailing edge. Each mode gives BITS strobes of each kind per transfer.
- R7: The leading edge moves sclk away from its inactive level (cpol = 0 means the leading edge is rising). A strobe is high in the cycle whose closing edge moves sclk. Shift and sample strobes are never high together.
- R8: A divLoad pulse while busy is ignored. A divLoad pulse while idle loads divIn, which then sets the half-period of the next transfer.
- R9: cpol and cpha are captured when a transfer starts. Changing them during a transfer changes neither sclk nor the strobes of that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| divIn | input | 8 | New divider value |
| divLoad | input | 1 | Divider write strobe; accepted only while idle |
| cpol | input | 1 | Clock polarity; inactive sclk level |
| cpha | input | 1 | Clock phase: 0 samples on leading edges, 1 on trailing edges |
| runReq | input | 1 | Level request to start a transfer |
| sclk | output | 1 | Serial clock |
| shiftStrobe | output | 1 | Launch outgoing data on this cycle's closing edge |
| sampleStrobe | output | 1 | Capture incoming data on this cycle's closing edge |
| busy | output | 1 | Transfer in progress |

## Verification
The assertions check on every cycle that sclk sits at the polarity input while idle, that the two strobes never coincide, and that a sample strobe appears only inside a transfer. They also check that every mid-transfer sclk edge was announced by a strobe one cycle earlier, and that busy rises only after a run request. Only the bench scenarios can show the exact half-period for each divider, the total transfer length, and the per-mode strobe counts and the sclk level at each strobe. The same goes for the divide-by-eight default after reset, the refusal of dividers 0 and 1, and the fact that divider loads and mode changes during a transfer have no effect.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
  typedef struct packed {
    logic startXfer;
    logic loadDiv;
    logic run;
  } ctl_strobes_t;
endpackage

// File: rtl/sclk_datapath.sv
module sclk_datapath import sclk_pkg::*; #(
  parameter int DIV_W = 8,
  parameter int RESET_DIV = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctl_strobes_t     ctl,
  input  logic [DIV_W-1:0] divIn,
  input  logic             cpol,
  output logic             halfDone,
  output logic             divOk,
  output logic             sclk
);
  localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(RESET_DIV);
  localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] divReg;
  logic [DIV_W-1:0] cnt;
  logic             level;
  logic             polHeld;

  // divider register, written only while idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divReg <= DIV_RST;
    else if (ctl.loadDiv) divReg <= divIn;
  end

  assign divOk    = divReg >= DIV_MIN;
  assign halfDone = ctl.run && (cnt == divReg);

  // modulus counter: counts 1..divReg, then reloads
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      level   <= 1'b0;
      polHeld <= 1'b0;
    end else if (ctl.startXfer) begin
      cnt     <= ONE;
      level   <= 1'b0;
      polHeld <= cpol;
    end else if (ctl.run) begin
      cnt <= halfDone ? ONE : cnt + ONE;
      if (halfDone) level <= ~level;
    end
  end

  assign sclk = ctl.run ? (polHeld ^ level) : cpol;
endmodule

// File: rtl/sclk_control.sv
module sclk_control import sclk_pkg::*; #(
  parameter int BITS = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         runReq,
  input  logic         divLoad,
  input  logic         cpha,
  input  logic         halfDone,
  input  logic         divOk,
  output ctl_strobes_t ctl,
  output logic         busy,
  output logic         shiftStrobe,
  output logic         sampleStrobe
);
  localparam int EW = $clog2(2 * BITS);
  localparam logic [EW-1:0] EDGE_LAST = EW'(2 * BITS - 1);
  localparam logic [EW-1:0] EDGE_ONE = EW'(1);

  logic [EW-1:0] edgeCnt;
  logic          phaseSel;
  logic          start;
  logic          leading;
  logic          lastEdge;

  // a divider write in the same cycle holds off the start by one cycle
  assign start    = runReq && !busy && divOk && !divLoad;
  assign leading  = ~edgeCnt[0];
  assign lastEdge = edgeCnt == EDGE_LAST;

  assign ctl.startXfer = start;
  assign ctl.loadDiv   = divLoad && !busy;
  assign ctl.run       = busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      edgeCnt  <= '0;
      phaseSel <= 1'b0;
    end else if (start) begin
      busy     <= 1'b1;
      edgeCnt  <= '0;
      phaseSel <= cpha;
    end else if (halfDone) begin
      edgeCnt <= edgeCnt + EDGE_ONE;
      if (lastEdge) busy <= 1'b0;
    end
  end

  assign sampleStrobe = halfDone && (phaseSel ? !leading : leading);
  assign shiftStrobe  = (start && !cpha) ||
                        (halfDone && (phaseSel ? leading : (!leading && !lastEdge)));
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen import sclk_pkg::*; #(
  parameter int DIV_W = 8,
  parameter int BITS = 8,
  parameter int RESET_DIV = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divIn,
  input  logic             divLoad,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             runReq,
  output logic             sclk,
  output logic             shiftStrobe,
  output logic             sampleStrobe,
  output logic             busy
);
  ctl_strobes_t ctl;
  logic         halfDone;
  logic         divOk;

  sclk_control #(.BITS(BITS)) i_ctl (
    .clk(clk), .rstN(rstN), .runReq(runReq), .divLoad(divLoad), .cpha(cpha),
    .halfDone(halfDone), .divOk(divOk), .ctl(ctl), .busy(busy),
    .shiftStrobe(shiftStrobe), .sampleStrobe(sampleStrobe)
  );

  sclk_datapath #(.DIV_W(DIV_W), .RESET_DIV(RESET_DIV)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .divIn(divIn), .cpol(cpol),
    .halfDone(halfDone), .divOk(divOk), .sclk(sclk)
  );
endmodule

// File: rtl/spi_sclk_gen_checker.sv
module spi_sclk_gen_checker (
  input logic clk,
  input logic rstN,
  input logic cpol,
  input logic runReq,
  input logic sclk,
  input logic shiftStrobe,
  input logic sampleStrobe,
  input logic busy
);
  // R5: idle clock parked at the polarity input
  a_r5_idle_park: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> sclk == cpol);

  // R7: strobes are mutually exclusive
  a_r7_strobe_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({shiftStrobe, sampleStrobe}));

  // R6: capture only happens inside a transfer
  a_r6_sample_in_xfer: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |-> busy);

  // R7: a mid-transfer sclk edge was announced one cycle earlier
  a_r7_edge_announced: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && sclk != $past(sclk)) |-> $past(shiftStrobe || sampleStrobe));

  // R2: a transfer starts only on request
  a_r2_start_on_request: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(runReq));
endmodule

bind spi_sclk_gen spi_sclk_gen_checker i_chk (
  .clk(clk), .rstN(rstN), .cpol(cpol), .runReq(runReq), .sclk(sclk),
  .shiftStrobe(shiftStrobe), .sampleStrobe(sampleStrobe), .busy(busy)
);

// File: tb/test_spi_sclk_gen.sv
module test_spi_sclk_gen;
  localparam int BITS = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] divIn = 8'd0;
  logic divLoad = 1'b0, cpol = 1'b0, cpha = 1'b0, runReq = 1'b0;
  logic sclk, shiftStrobe, sampleStrobe, busy;

  int checks = 0, fails = 0, cycles = 0;

  // monitor state
  logic mon = 1'b0, prevSclk = 1'b0, expPol = 1'b0, expPha = 1'b0;
  int busyCyc, edges, runLen, expHalf, halfErr, levelErr, shiftCnt, sampleCnt;

  spi_sclk_gen i_spi_sclk_gen (
    .clk(clk), .rstN(rstN), .divIn(divIn), .divLoad(divLoad), .cpol(cpol),
    .cpha(cpha), .runReq(runReq), .sclk(sclk), .shiftStrobe(shiftStrobe),
    .sampleStrobe(sampleStrobe), .busy(busy)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (mon) begin
      if (busy) busyCyc++;
      if (shiftStrobe) shiftCnt++;
      if (sampleStrobe) sampleCnt++;
      if (busy && sampleStrobe && sclk != (expPha ? !expPol : expPol)) levelErr++;
      if (busy && shiftStrobe && sclk != (expPha ? expPol : !expPol)) levelErr++;
      if (sclk != prevSclk) begin
        edges++;
        if (runLen != expHalf) halfErr++;
        runLen = 1;
      end else if (busy) runLen++;
      prevSclk = sclk;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic stepIn();
    @(posedge clk); #2;
  endtask

  task automatic loadDiv(input int d);
    stepIn(); divIn = 8'(d); divLoad = 1'b1;
    stepIn(); divLoad = 1'b0;
  endtask

  // run one transfer; midFlip toggles cpol/cpha for a few cycles mid-transfer
  task automatic runXfer(input string req, input int d, input bit pol, input bit pha, input bit midFlip);
    stepIn();
    cpol = pol; cpha = pha;
    stepIn();
    expPol = pol; expPha = pha; expHalf = d;
    busyCyc = 0; edges = 0; runLen = 0; halfErr = 0; levelErr = 0;
    shiftCnt = 0; sampleCnt = 0; prevSclk = pol;
    runReq = 1'b1; mon = 1'b1;
    @(negedge clk);
    chk(shiftStrobe == !pha, "R6", "start shift strobe", int'(shiftStrobe), int'(!pha));
    stepIn(); runReq = 1'b0;
    if (midFlip) begin
      repeat (d + 1) stepIn();
      cpol = !pol; cpha = !pha;
      repeat (3) stepIn();
      cpol = pol; cpha = pha;
    end
    for (int i = 0; i < 2 * BITS * 255 + 50 && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    mon = 1'b0;
    chk(busyCyc == 2 * BITS * d, req, "busy cycles", busyCyc, 2 * BITS * d);
    chk(edges == 2 * BITS, req, "sclk edges", edges, 2 * BITS);
    chk(halfErr == 0, "R1", "half-period errors", halfErr, 0);
    chk(levelErr == 0, "R7", "sclk level at strobe", levelErr, 0);
    chk(shiftCnt == BITS, "R6", "shift strobes", shiftCnt, BITS);
    chk(sampleCnt == BITS, "R6", "sample strobes", sampleCnt, BITS);
    chk(sclk == pol, "R2", "sclk after transfer", int'(sclk), int'(pol));
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(!busy, "R4", "busy after reset", int'(busy), 0);
    chk(!shiftStrobe && !sampleStrobe, "R4", "strobes after reset", int'({shiftStrobe, sampleStrobe}), 0);
    chk(sclk == 1'b0, "R5", "idle sclk cpol=0", int'(sclk), 0);
    stepIn(); cpol = 1'b1;
    @(negedge clk);
    chk(sclk == 1'b1, "R5", "idle sclk cpol=1", int'(sclk), 1);
    stepIn(); cpol = 1'b0;
  endtask

  task automatic testDisabled(input int d);
    loadDiv(d);
    stepIn(); cpol = 1'b1; runReq = 1'b1;
    begin
      int strobeSeen = 0, busySeen = 0, parkBad = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (shiftStrobe || sampleStrobe) strobeSeen++;
        if (busy) busySeen++;
        if (sclk != 1'b1) parkBad++;
      end
      chk(busySeen == 0, "R3", "busy with divider<2", busySeen, 0);
      chk(strobeSeen == 0, "R3", "strobes with divider<2", strobeSeen, 0);
      chk(parkBad == 0, "R3", "sclk parked", parkBad, 0);
    end
    stepIn(); runReq = 1'b0; cpol = 1'b0;
  endtask

  task automatic testLoadWhileBusy();
    loadDiv(3);
    stepIn(); cpol = 1'b0; cpha = 1'b0; runReq = 1'b1;
    stepIn(); runReq = 1'b0;
    repeat (5) stepIn();
    divIn = 8'd6; divLoad = 1'b1;
    stepIn(); divLoad = 1'b0;
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    // next transfer must still use divider 3
    runXfer("R8", 3, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    testReset();
    runXfer("R4", 4, 1'b0, 1'b0, 1'b0);
    loadDiv(2);
    runXfer("R2", 2, 1'b0, 1'b0, 1'b0);
    loadDiv(3);
    runXfer("R2", 3, 1'b1, 1'b0, 1'b0);
    loadDiv(5);
    runXfer("R1", 5, 1'b0, 1'b1, 1'b0);
    loadDiv(2);
    runXfer("R1", 2, 1'b1, 1'b1, 1'b0);
    loadDiv(255);
    runXfer("R1", 255, 1'b0, 1'b1, 1'b0);
    loadDiv(6);
    runXfer("R9", 6, 1'b0, 1'b0, 1'b1);
    runXfer("R9", 6, 1'b1, 1'b1, 1'b1);
    testDisabled(0);
    testDisabled(1);
    testLoadWhileBusy();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule